// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

A small, fully associative cache that holds virtual-page to physical-page translations for one hardware thread. Every entry carries either the address-space identifier (ASID) it was filled under or a global flag. The ASID register value is an input: lookups and fills are checked against it in the cycle they are presented. A page-table walker writes results through the fill port. A lookup returns hit, physical page number and stored permission bits one cycle after the request.

Changing the current ASID or the root pointer does not invalidate anything. Entries of other address spaces stay resident, cannot be matched while another ASID is current, and become usable again when their ASID returns. Only the fence port removes entries. A fence can name a virtual page, an ASID, both, or neither. Fills from speculative walks have no fault path. A fault is flagged only for a lookup marked as belonging to a retiring instruction.

Top module: `asid_tlb`

## Requirements
- R1: After synchronous reset every entry is invalid, the replacement pointer is at entry 0, and `rsp_valid`, `rsp_hit` and `rsp_fault` are low.
- R2: A lookup presented with `lk_valid` high produces `rsp_valid` high on the next cycle only. `rsp_ppn` and `rsp_perm` then carry the stored fields of the matching entry, or zero on a miss. When several entries match, the lowest-numbered entry wins.
- R3: A lookup hits only an entry whose virtual page equals `lk_vpn` and that is either global or tagged with `cur_asid`.
- R4: A fill creates or updates an entry only when `fill_global` is high or `fill_asid` equals `cur_asid`. Any other fill leaves the cache unchanged.
- R5: A change of `cur_asid` removes no entry. An entry filled under ASID A hits again once `cur_asid` returns to A.
- R6: A fence with `fence_use_va` and `fence_use_asid` both low invalidates every entry, global ones included.
- R7: A fence with only `fence_use_asid` high invalidates the non-global entries tagged `fence_asid`. Global entries and entries of other ASIDs are kept.
- R8: A fence with only `fence_use_va` high invalidates every entry for page `fence_vpn`, whatever its ASID or global flag.
- R9: A fence with both selectors high invalidates only the non-global entries that match both `fence_vpn` and `fence_asid`.
- R10: In a cycle with both a fence and a fill, the fence is applied first and the fill is placed afterwards. A lookup in that cycle sees the contents from before both.
- R11: An accepted fill goes to the first slot that applies, in this order. (1) A valid entry with the same page, the same global flag and, if non-global, the same ASID is overwritten in place. (2) Otherwise the lowest-numbered invalid entry is used. (3) Otherwise the entry at the round-robin pointer is replaced, and the pointer then advances by one modulo the entry count. Only case (3) moves the pointer.
- R12: `rsp_fault` is high only in the response to a lookup that had `lk_retire` high and missed. Fills never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_asid | input | ASID_W | ASID currently held in the translation control register |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_retire | input | 1 | Lookup belongs to a retiring instruction (may fault) |
| rsp_valid | output | 1 | Lookup response valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Physical page number on hit, else zero |
| rsp_perm | output | PERM_W | Stored permission bits on hit, else zero |
| rsp_fault | output | 1 | Retiring lookup missed |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vpn | input | VPN_W | Fill virtual page number |
| fill_asid | input | ASID_W | ASID the walk was made under |
| fill_global | input | 1 | Fill is a global mapping |
| fill_ppn | input | PPN_W | Fill physical page number |
| fill_perm | input | PERM_W | Fill permission bits |
| fence_valid | input | 1 | Fence request |
| fence_use_va | input | 1 | Fence is limited to `fence_vpn` |
| fence_vpn | input | VPN_W | Page the fence targets |
| fence_use_asid | input | 1 | Fence is limited to `fence_asid` |
| fence_asid | input | ASID_W | ASID the fence targets |

## Verification
A lookup result comes out of one register and is due exactly one cycle after the request. The bench drives inputs on the falling edge, lets one rising edge pass, and compares on the next falling edge against a model that answers from the contents before that cycle's fill and fence. Fills and fences take effect at the same rising edge, so their effect is checked with a lookup issued in the following cycle, which answers one cycle later again. Idle cycles are checked too: `rsp_valid`, `rsp_hit` and `rsp_fault` must be low in the cycle after no lookup was presented.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

    typedef enum logic [1:0] {
        FENCE_ALL       = 2'd0,
        FENCE_ASID      = 2'd1,
        FENCE_PAGE      = 2'd2,
        FENCE_PAGE_ASID = 2'd3
    } fence_kind_e;

    function automatic fence_kind_e fence_decode(input logic use_va, input logic use_asid);
        if (use_va)
            return use_asid ? FENCE_PAGE_ASID : FENCE_PAGE;
        return use_asid ? FENCE_ASID : FENCE_ALL;
    endfunction

endpackage

// File: rtl/tlb_fence.sv
`timescale 1ns/1ps
module tlb_fence
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 9
) (
    input  logic                              fence_valid,
    input  logic                              use_va,
    input  logic [VPN_W-1:0]                  tgt_vpn,
    input  logic                              use_asid,
    input  logic [ASID_W-1:0]                 tgt_asid,
    input  logic [ENTRIES-1:0]                ent_glob,
    input  logic [ENTRIES-1:0][VPN_W-1:0]     ent_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0]    ent_asid,
    output logic [ENTRIES-1:0]                kill
);
    fence_kind_e kind;
    assign kind = fence_decode(use_va, use_asid);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_kill
        logic page_eq, asid_eq;
        assign page_eq = (ent_vpn[i] == tgt_vpn);
        assign asid_eq = !ent_glob[i] && (ent_asid[i] == tgt_asid);
        always_comb begin
            unique case (kind)
                FENCE_ALL:       kill[i] = fence_valid;
                FENCE_ASID:      kill[i] = fence_valid && asid_eq;
                FENCE_PAGE:      kill[i] = fence_valid && page_eq;
                FENCE_PAGE_ASID: kill[i] = fence_valid && asid_eq && page_eq;
                default:         kill[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tlb_lookup.sv
`timescale 1ns/1ps
module tlb_lookup #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 9,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]                ent_valid,
    input  logic [ENTRIES-1:0]                ent_glob,
    input  logic [ENTRIES-1:0][VPN_W-1:0]     ent_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0]    ent_asid,
    input  logic [VPN_W-1:0]                  key_vpn,
    input  logic [ASID_W-1:0]                 key_asid,
    input  logic                              key_glob,
    input  logic                              exact,
    output logic                              hit,
    output logic [IDX_W-1:0]                  idx
);
    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_match
        logic tag_ok;
        always_comb begin
            if (exact)
                tag_ok = (ent_glob[i] == key_glob) && (key_glob || ent_asid[i] == key_asid);
            else
                tag_ok = ent_glob[i] || (ent_asid[i] == key_asid);
        end
        assign match[i] = ent_valid[i] && (ent_vpn[i] == key_vpn) && tag_ok;
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (match[i]) idx = IDX_W'(i);
    end
    assign hit = |match;
endmodule

// File: rtl/tlb_alloc.sv
`timescale 1ns/1ps
module tlb_alloc #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ENTRIES-1:0]   kept,
    input  logic                 fill_ok,
    input  logic                 dup_hit,
    input  logic [IDX_W-1:0]     dup_idx,
    output logic [IDX_W-1:0]     victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q, free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (!kept[i]) free_idx = IDX_W'(i);
    end
    assign any_free = |(~kept);

    always_comb begin
        if (dup_hit)       victim = dup_idx;
        else if (any_free) victim = free_idx;
        else               victim = rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (fill_ok && !dup_hit && !any_free)
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    // R11
    rr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rr_q != $past(rr_q)) |-> (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1)));

    // R11
    rr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_ok |=> $stable(rr_q));
endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ASID_W  = 9,
    parameter int PERM_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_retire,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              rsp_fault,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fence_valid,
    input  logic              fence_use_va,
    input  logic [VPN_W-1:0]  fence_vpn,
    input  logic              fence_use_asid,
    input  logic [ASID_W-1:0] fence_asid
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } tlb_entry_t;

    tlb_entry_t                      ent_q [ENTRIES];
    logic [ENTRIES-1:0]              valid_q, valid_d, kill, kept, glob_vec;
    logic [ENTRIES-1:0][VPN_W-1:0]   vpn_vec;
    logic [ENTRIES-1:0][ASID_W-1:0]  asid_vec;
    logic                            lk_hit, dup_hit, fill_ok;
    logic [IDX_W-1:0]                lk_idx, dup_idx, victim;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            glob_vec[i] = ent_q[i].glob;
            vpn_vec[i]  = ent_q[i].vpn;
            asid_vec[i] = ent_q[i].asid;
        end
    end

    tlb_fence #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fence (
        .fence_valid(fence_valid), .use_va(fence_use_va), .tgt_vpn(fence_vpn),
        .use_asid(fence_use_asid), .tgt_asid(fence_asid),
        .ent_glob(glob_vec), .ent_vpn(vpn_vec), .ent_asid(asid_vec), .kill(kill)
    );

    assign kept = valid_q & ~kill;

    tlb_lookup #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk (
        .ent_valid(valid_q), .ent_glob(glob_vec), .ent_vpn(vpn_vec), .ent_asid(asid_vec),
        .key_vpn(lk_vpn), .key_asid(cur_asid), .key_glob(1'b0), .exact(1'b0),
        .hit(lk_hit), .idx(lk_idx)
    );

    tlb_lookup #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_dup (
        .ent_valid(kept), .ent_glob(glob_vec), .ent_vpn(vpn_vec), .ent_asid(asid_vec),
        .key_vpn(fill_vpn), .key_asid(fill_asid), .key_glob(fill_global), .exact(1'b1),
        .hit(dup_hit), .idx(dup_idx)
    );

    assign fill_ok = fill_valid && (fill_global || fill_asid == cur_asid);

    tlb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk(clk), .rst(rst), .kept(kept), .fill_ok(fill_ok),
        .dup_hit(dup_hit), .dup_idx(dup_idx), .victim(victim)
    );

    always_comb begin
        valid_d = kept;
        if (fill_ok) valid_d[victim] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_perm  <= '0;
            rsp_fault <= 1'b0;
        end else begin
            valid_q <= valid_d;
            if (fill_ok)
                ent_q[victim] <= '{glob: fill_global, asid: fill_asid, vpn: fill_vpn,
                                   ppn: fill_ppn, perm: fill_perm};
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_hit;
            rsp_ppn   <= (lk_valid && lk_hit) ? ent_q[lk_idx].ppn  : '0;
            rsp_perm  <= (lk_valid && lk_hit) ? ent_q[lk_idx].perm : '0;
            rsp_fault <= lk_valid && lk_retire && !lk_hit;
        end
    end

    // R4
    drop_foreign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_global && fill_asid != cur_asid && !fence_valid)
        |=> (valid_q == $past(valid_q)));

    // R5
    idle_keeps_entries_chk: assert property (@(posedge clk) disable iff (rst)
        (!fill_valid && !fence_valid) |=> (valid_q == $past(valid_q)));

    // R6
    fence_all_chk: assert property (@(posedge clk) disable iff (rst)
        (fence_valid && !fence_use_va && !fence_use_asid && !fill_valid) |=> (valid_q == '0));

    // R7
    fence_asid_keeps_global_chk: assert property (@(posedge clk) disable iff (rst)
        (fence_valid && fence_use_asid && !fence_use_va && !fill_valid)
        |=> ((valid_q & glob_vec) == $past(valid_q & glob_vec)));

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

    // R12
    fault_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && !rsp_hit));
endmodule

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;
    localparam int N      = 8;
    localparam int VPN_W  = 20;
    localparam int PPN_W  = 20;
    localparam int ASID_W = 9;
    localparam int PERM_W = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic [ASID_W-1:0] cur_asid;
    logic              lk_valid, lk_retire;
    logic [VPN_W-1:0]  lk_vpn;
    logic              rsp_valid, rsp_hit, rsp_fault;
    logic [PPN_W-1:0]  rsp_ppn;
    logic [PERM_W-1:0] rsp_perm;
    logic              fill_valid, fill_global;
    logic [VPN_W-1:0]  fill_vpn;
    logic [ASID_W-1:0] fill_asid;
    logic [PPN_W-1:0]  fill_ppn;
    logic [PERM_W-1:0] fill_perm;
    logic              fence_valid, fence_use_va, fence_use_asid;
    logic [VPN_W-1:0]  fence_vpn;
    logic [ASID_W-1:0] fence_asid;

    asid_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .PERM_W(PERM_W)) u_asid_tlb (
        .clk(clk), .rst(rst), .cur_asid(cur_asid),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_retire(lk_retire),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_global(fill_global), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .fence_valid(fence_valid), .fence_use_va(fence_use_va), .fence_vpn(fence_vpn),
        .fence_use_asid(fence_use_asid), .fence_asid(fence_asid)
    );

    int total = 0;
    int fails = 0;

    // reference model
    logic              m_v    [N];
    logic              m_g    [N];
    logic [ASID_W-1:0] m_asid [N];
    logic [VPN_W-1:0]  m_vpn  [N];
    logic [PPN_W-1:0]  m_ppn  [N];
    logic [PERM_W-1:0] m_perm [N];
    int                m_rr;

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_g[i] = 1'b0; m_asid[i] = '0;
            m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
        end
        m_rr = 0;
    endtask

    task automatic model_lookup(output logic hit, output logic [PPN_W-1:0] ppn,
                                output logic [PERM_W-1:0] perm);
        hit = 1'b0; ppn = '0; perm = '0;
        for (int i = 0; i < N; i++)
            if (!hit && m_v[i] && m_vpn[i] == lk_vpn && (m_g[i] || m_asid[i] == cur_asid)) begin
                hit = 1'b1; ppn = m_ppn[i]; perm = m_perm[i];
            end
    endtask

    task automatic model_update();
        int slot;
        if (fence_valid)
            for (int i = 0; i < N; i++) begin
                logic k;
                if (!fence_use_va && !fence_use_asid) k = 1'b1;
                else if (!fence_use_va)               k = !m_g[i] && m_asid[i] == fence_asid;
                else if (!fence_use_asid)             k = m_vpn[i] == fence_vpn;
                else k = !m_g[i] && m_asid[i] == fence_asid && m_vpn[i] == fence_vpn;
                if (k) m_v[i] = 1'b0;
            end
        if (fill_valid && (fill_global || fill_asid == cur_asid)) begin
            slot = -1;
            for (int i = 0; i < N; i++)
                if (slot < 0 && m_v[i] && m_vpn[i] == fill_vpn && m_g[i] == fill_global &&
                    (fill_global || m_asid[i] == fill_asid)) slot = i;
            if (slot < 0)
                for (int i = 0; i < N; i++)
                    if (slot < 0 && !m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[slot] = 1'b1; m_g[slot] = fill_global; m_asid[slot] = fill_asid;
            m_vpn[slot] = fill_vpn; m_ppn[slot] = fill_ppn; m_perm[slot] = fill_perm;
        end
    endtask

    task automatic idle();
        lk_valid = 1'b0; lk_vpn = '0; lk_retire = 1'b0;
        fill_valid = 1'b0; fill_vpn = '0; fill_asid = '0; fill_global = 1'b0;
        fill_ppn = '0; fill_perm = '0;
        fence_valid = 1'b0; fence_use_va = 1'b0; fence_vpn = '0;
        fence_use_asid = 1'b0; fence_asid = '0;
    endtask

    // one cycle: predict, advance model, pass a rising edge, compare at the falling edge
    task automatic tick(input logic want_chk, input logic want_hit, input string tag);
        logic              e_valid, e_hit, e_fault;
        logic [PPN_W-1:0]  e_ppn;
        logic [PERM_W-1:0] e_perm;
        logic              bad;
        e_valid = lk_valid;
        model_lookup(e_hit, e_ppn, e_perm);
        if (!lk_valid) begin e_hit = 1'b0; e_ppn = '0; e_perm = '0; end
        e_fault = lk_valid && lk_retire && !e_hit;
        model_update();
        @(posedge clk);
        @(negedge clk);
        total++;
        bad = (rsp_valid !== e_valid) || (rsp_hit !== e_hit) || (rsp_ppn !== e_ppn) ||
              (rsp_perm !== e_perm) || (rsp_fault !== e_fault) ||
              (want_chk && (e_hit !== want_hit));
        if (bad) begin
            fails++;
            $display("FAIL %s: got v=%0d hit=%0d ppn=%h perm=%h fault=%0d expected v=%0d hit=%0d(%0d) ppn=%h perm=%h fault=%0d",
                     tag, rsp_valid, rsp_hit, rsp_ppn, rsp_perm, rsp_fault,
                     e_valid, e_hit, want_hit, e_ppn, e_perm, e_fault);
        end
        idle();
    endtask

    task automatic do_fill(input int vpn, input int asid, input logic g, input int ppn, input string tag);
        fill_valid = 1'b1; fill_vpn = VPN_W'(vpn); fill_asid = ASID_W'(asid);
        fill_global = g; fill_ppn = PPN_W'(ppn); fill_perm = PERM_W'(ppn);
        tick(1'b0, 1'b0, tag);
    endtask

    task automatic do_look(input int vpn, input logic retire, input logic want_hit, input string tag);
        lk_valid = 1'b1; lk_vpn = VPN_W'(vpn); lk_retire = retire;
        tick(1'b1, want_hit, tag);
    endtask

    task automatic do_fence(input logic use_va, input int vpn, input logic use_asid, input int asid,
                            input string tag);
        fence_valid = 1'b1; fence_use_va = use_va; fence_vpn = VPN_W'(vpn);
        fence_use_asid = use_asid; fence_asid = ASID_W'(asid);
        tick(1'b0, 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL R2: watchdog expired, got hung run expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd20240611);
        idle();
        cur_asid = ASID_W'(1);
        rst = 1'b1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        total++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_fault !== 1'b0) begin
            fails++;
            $display("FAIL R1: got v=%0d hit=%0d fault=%0d expected 0 0 0", rsp_valid, rsp_hit, rsp_fault);
        end
        do_look(5, 1'b0, 1'b0, "R1 empty after reset");

        // R2 / R4 basic fill and hit
        do_fill(5, 1, 1'b0, 'h123, "R4 own fill");
        do_look(5, 1'b0, 1'b1, "R2 hit after fill");
        do_fill(6, 2, 1'b0, 'h456, "R4 foreign fill");
        do_look(6, 1'b0, 1'b0, "R4 foreign fill dropped");

        // R3 / R5 global and ASID switching
        do_fill(7, 3, 1'b1, 'h777, "R3 global fill");
        cur_asid = ASID_W'(2);
        do_look(7, 1'b0, 1'b1, "R3 global hits other asid");
        do_look(5, 1'b0, 1'b0, "R3 asid1 entry hidden");
        cur_asid = ASID_W'(1);
        do_look(5, 1'b0, 1'b1, "R5 entry back after switch");

        // R7 fence by asid
        do_fence(1'b0, 0, 1'b1, 1, "R7 fence asid1");
        do_look(5, 1'b0, 1'b0, "R7 asid entry removed");
        do_look(7, 1'b0, 1'b1, "R7 global kept");

        // R8 fence by page
        do_fill(5, 1, 1'b0, 'h155, "R8 refill");
        do_fence(1'b1, 7, 1'b0, 0, "R8 fence page7");
        do_look(7, 1'b0, 1'b0, "R8 global page removed");
        do_look(5, 1'b0, 1'b1, "R8 other page kept");

        // R9 fence by page and asid
        do_fill(8, 1, 1'b0, 'h181, "R9 fill asid1");
        cur_asid = ASID_W'(2);
        do_fill(8, 2, 1'b0, 'h182, "R9 fill asid2");
        do_fence(1'b1, 8, 1'b1, 1, "R9 fence page8 asid1");
        do_look(8, 1'b0, 1'b1, "R9 asid2 copy kept");
        cur_asid = ASID_W'(1);
        do_look(8, 1'b0, 1'b0, "R9 asid1 copy removed");

        // R6 fence all
        do_fill(9, 0, 1'b1, 'h999, "R6 global fill");
        do_fence(1'b0, 0, 1'b0, 0, "R6 fence all");
        do_look(9, 1'b0, 1'b0, "R6 global removed");
        do_look(5, 1'b0, 1'b0, "R6 asid entry removed");

        // R10 fence and fill in one cycle, lookup sees old contents
        do_fill(5, 1, 1'b0, 'h505, "R10 setup");
        fence_valid = 1'b1;
        fill_valid = 1'b1; fill_vpn = VPN_W'(3); fill_asid = ASID_W'(1); fill_ppn = PPN_W'('h303);
        fill_perm = PERM_W'(3);
        lk_valid = 1'b1; lk_vpn = VPN_W'(5);
        tick(1'b1, 1'b1, "R10 lookup sees pre-fence state");
        do_look(3, 1'b0, 1'b1, "R10 fill after fence survives");
        do_look(5, 1'b0, 1'b0, "R10 fence removed old");

        // R11 replacement
        do_fence(1'b0, 0, 1'b0, 0, "R11 clear");
        for (int k = 0; k < N; k++) do_fill(10 + k, 1, 1'b0, 'h1000 + k, "R11 fill free");
        do_fill(18, 1, 1'b0, 'h1018, "R11 evict rr0");
        do_look(10, 1'b0, 1'b0, "R11 slot0 evicted");
        do_look(11, 1'b0, 1'b1, "R11 slot1 kept");
        do_look(18, 1'b0, 1'b1, "R11 new entry");
        do_fill(19, 1, 1'b0, 'h1019, "R11 evict rr1");
        do_look(11, 1'b0, 1'b0, "R11 slot1 evicted");
        do_fill(12, 1, 1'b0, 'h2012, "R11 duplicate overwrite");
        do_look(12, 1'b0, 1'b1, "R11 duplicate new ppn");
        do_fill(20, 1, 1'b0, 'h1020, "R11 evict rr2");
        do_look(12, 1'b0, 1'b0, "R11 pointer held on duplicate");
        do_look(13, 1'b0, 1'b1, "R11 slot3 kept");

        // R12 faults
        do_look(99, 1'b1, 1'b0, "R12 retire miss faults");
        do_look(13, 1'b1, 1'b1, "R12 retire hit no fault");
        do_look(98, 1'b0, 1'b0, "R12 speculative miss no fault");
        do_fill(30, 1, 1'b0, 'h3030, "R12 fill raises no fault");

        // random traffic
        for (int c = 0; c < 3000; c++) begin
            if ($urandom % 20 == 0) cur_asid = ASID_W'($urandom % 4);
            if ($urandom % 10 < 7) begin
                lk_valid = 1'b1; lk_vpn = VPN_W'($urandom % 16); lk_retire = 1'($urandom % 2);
            end
            if ($urandom % 10 < 4) begin
                fill_valid = 1'b1; fill_vpn = VPN_W'($urandom % 16);
                fill_asid = ASID_W'($urandom % 4); fill_global = ($urandom % 8 == 0);
                fill_ppn = PPN_W'($urandom); fill_perm = PERM_W'($urandom);
            end
            if ($urandom % 20 == 0) begin
                fence_valid = 1'b1; fence_use_va = 1'($urandom % 2); fence_vpn = VPN_W'($urandom % 16);
                fence_use_asid = 1'($urandom % 2); fence_asid = ASID_W'($urandom % 4);
            end
            tick(1'b0, 1'b0, "R2 random traffic");
        end

        finish_run();
    end
endmodule